// File: doc/BRIEF.md
# Nonvolatile-Memory Timing Clock Divider

This block turns the bus clock into the slow timing strobe that paces program and erase pulses in an on-chip nonvolatile array. Software writes one configuration byte that holds a 6-bit divide value and a divide-by-eight prescale enable. The block then emits a one-cycle enable pulse once per divided period. The timing logic of the array uses that pulse as a clock enable.

The configuration can be written once per reset. The first write is taken and raises a loaded flag, and every later write is dropped until the next reset. At the moment of the write, the prescaler and the main counter both start again from zero, so the first pulse comes one full period later. From the bus frequency parameter and the chosen ratio, the block also flags a setting whose derived rate lies outside the 150 kHz to 200 kHz band. That band corresponds to a period of about 5 µs to 6.7 µs.

Top module: `nvm_tick_divider`

## Requirements
- R1: While reset is held, and until the first write, `tick_o`, `loaded_o` and `range_err_o` are all 0.
- R2: The first `wr_en` after reset is accepted, and `loaded_o` is 1 from the following cycle. Any `wr_en` while `loaded_o` is 1 changes neither the pulse spacing nor `range_err_o`.
- R3: `wr_data[5:0]` is the divide value DIV and `wr_data[6]` is the prescale enable. `wr_data[7]` has no effect.
- R4: With the prescale enable at 0, `tick_o` pulses once every DIV+1 bus cycles.
- R5: With the prescale enable at 1, `tick_o` pulses once every 8×(DIV+1) bus cycles.
- R6: With DIV = 0 and the prescale enable at 0, `tick_o` is high on every cycle, so the bus rate passes through undivided.
- R7: When the ratio is above 1, each pulse on `tick_o` is exactly one bus cycle wide.
- R8: The first pulse after an accepted write appears exactly one full ratio of cycles after the write cycle, with no partial period.
- R9: With ratio = (prescale ? 8 : 1)×(DIV+1), `range_err_o` is 1 when BUS_KHZ > 200×ratio or BUS_KHZ < 150×ratio. It changes in the same cycle as `loaded_o`.
- R10: No pulse appears on `tick_o` while `loaded_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released on clk |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 8 | Configuration byte: [5:0] divide value, [6] prescale enable |
| tick_o | output | 1 | One-cycle enable at the divided rate |
| loaded_o | output | 1 | Configuration has been accepted |
| range_err_o | output | 1 | Derived rate lies outside 150 to 200 kHz |

## Verification
The bench sweeps settings on both sides of the rate band at a 20 MHz bus: 96 cycles (208 kHz) against 104 cycles (192 kHz), and 128 cycles (156 kHz) against 136 cycles (147 kHz). A flag comparison that is off by one or inverted then shows up at once. It measures the delay from the write to the first pulse as well as the steady spacing, which exposes a counter that does not restart or a compare of cnt against DIV+1. It also sets bit 7 and rewrites after loading to catch a wrongly decoded field or a register that is not locked. The undivided setting and the largest ratio (512 cycles) cover a counter that never fires at DIV = 0 or wraps early.

// File: rtl/nvm_div_pkg.sv
package nvm_div_pkg;
  localparam int DIV_W  = 6;
  localparam int DATA_W = DIV_W + 2;

  typedef struct packed {
    logic             pre;
    logic [DIV_W-1:0] div;
  } div_cfg_t;
endpackage

// File: rtl/nvm_div_cfg.sv
module nvm_div_cfg
  import nvm_div_pkg::*;
#(
  parameter int BUS_KHZ   = 20000,
  parameter int PRE_RATIO = 8,
  parameter int MIN_KHZ   = 150,
  parameter int MAX_KHZ   = 200
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output div_cfg_t          cfg_o,
  output logic              loaded_o,
  output logic              range_err_o,
  output logic              accept_o
);
  div_cfg_t cfg_q, cfg_d;
  logic     loaded_q, loaded_d;
  logic     err_q, err_d;
  div_cfg_t wr_cfg;

  function automatic logic rate_bad(div_cfg_t c);
    int unsigned ratio;
    ratio = (c.pre ? PRE_RATIO : 1) * (int'(c.div) + 1);
    return (BUS_KHZ > MAX_KHZ * ratio) || (BUS_KHZ < MIN_KHZ * ratio);
  endfunction

  assign wr_cfg.pre = wr_data[DIV_W];
  assign wr_cfg.div = wr_data[DIV_W-1:0];
  assign accept_o   = wr_en && !loaded_q;

  always_comb begin
    cfg_d    = cfg_q;
    loaded_d = loaded_q;
    err_d    = err_q;
    if (accept_o) begin
      cfg_d    = wr_cfg;
      loaded_d = 1'b1;
      err_d    = rate_bad(wr_cfg);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      loaded_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      loaded_q <= loaded_d;
      err_q    <= err_d;
    end
  end

  assign cfg_o       = cfg_q;
  assign loaded_o    = loaded_q;
  assign range_err_o = err_q;

  p_loaded_sticky_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    loaded_q |=> loaded_q);
  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    loaded_q |=> ($stable(cfg_q) && $stable(err_q)));
  p_load_on_write_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !loaded_q) |=> loaded_q);
endmodule

// File: rtl/nvm_div_prescale.sv
module nvm_div_prescale #(
  parameter int PRE_RATIO = 8
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic run_i,
  input  logic pre_i,
  output logic stage_en_o
);
  generate
    if (PRE_RATIO > 1) begin : g_pre
      localparam int PW = $clog2(PRE_RATIO);
      logic [PW-1:0] pcnt_q, pcnt_d;
      logic          wrap;

      assign wrap = (pcnt_q == PW'(PRE_RATIO - 1));

      always_comb begin
        pcnt_d = pcnt_q;
        if (!run_i || !pre_i) pcnt_d = '0;
        else if (wrap)        pcnt_d = '0;
        else                  pcnt_d = pcnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) pcnt_q <= '0;
        else         pcnt_q <= pcnt_d;
      end

      assign stage_en_o = run_i && (pre_i ? wrap : 1'b1);

      p_pre_gap_r5: assert property (@(posedge clk) disable iff (!rst_ni)
        (stage_en_o && pre_i && run_i) |=> !stage_en_o);
    end else begin : g_nopre
      assign stage_en_o = run_i;
    end
  endgenerate
endmodule

// File: rtl/nvm_div_counter.sv
module nvm_div_counter #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             stage_en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!run_i) begin
      cnt_d = '0;
    end else if (stage_en_i) begin
      if (cnt_q == div_i) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    run_i |-> (cnt_q <= div_i));
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick_q && run_i && div_i != '0) |=> !tick_q);
endmodule

// File: rtl/nvm_tick_divider.sv
module nvm_tick_divider
  import nvm_div_pkg::*;
#(
  parameter int BUS_KHZ   = 20000,
  parameter int PRE_RATIO = 8,
  parameter int MIN_KHZ   = 150,
  parameter int MAX_KHZ   = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tick_o,
  output logic              loaded_o,
  output logic              range_err_o
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  div_cfg_t   cfg;
  logic       loaded, accept, stage_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  nvm_div_cfg #(
    .BUS_KHZ(BUS_KHZ), .PRE_RATIO(PRE_RATIO),
    .MIN_KHZ(MIN_KHZ), .MAX_KHZ(MAX_KHZ)
  ) u_cfg (
    .clk(clk), .rst_ni(rst_ni), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_o(cfg), .loaded_o(loaded), .range_err_o(range_err_o),
    .accept_o(accept)
  );

  nvm_div_prescale #(.PRE_RATIO(PRE_RATIO)) u_pre (
    .clk(clk), .rst_ni(rst_ni), .run_i(loaded), .pre_i(cfg.pre),
    .stage_en_o(stage_en)
  );

  nvm_div_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst_ni(rst_ni), .run_i(loaded), .stage_en_i(stage_en),
    .div_i(cfg.div), .tick_o(tick_o)
  );

  assign loaded_o = loaded;

  p_no_tick_unloaded_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !loaded |-> !tick_o);
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    accept |=> !tick_o);
endmodule

// File: tb/nvm_tick_divider_bench.sv
module nvm_tick_divider_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       tick_o, loaded_o, range_err_o;
  int         errors = 0;
  int         checks = 0;

  always #10 clk = ~clk;

  nvm_tick_divider u_nvm_tick_divider (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tick_o(tick_o), .loaded_o(loaded_o), .range_err_o(range_err_o)
  );

  // {data[7:0], period[11:0], range_err}
  localparam int NV = 9;
  localparam logic [20:0] VEC [NV] = '{
    {8'h4C, 12'd104, 1'b0},
    {8'h31, 12'd50,  1'b1},
    {8'h00, 12'd1,   1'b1},
    {8'h4F, 12'd128, 1'b0},
    {8'h50, 12'd136, 1'b1},
    {8'h4B, 12'd96,  1'b1},
    {8'h3F, 12'd64,  1'b1},
    {8'hCD, 12'd112, 1'b0},
    {8'h7F, 12'd512, 1'b1}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // counts negedges until tick seen; returns 0 when not seen
  task automatic wait_tick(output int n);
    n = 0;
    for (int i = 1; i <= 2000; i++) begin
      @(negedge clk);
      if (tick_o) begin n = i; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int n, n2, per;
    logic er;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (2) @(negedge clk);
    chk(!tick_o && !loaded_o && !range_err_o, "R1 reset outputs", {tick_o, loaded_o, range_err_o}, 0);
    do_reset();
    // R10: nothing before loading
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tick_o) chk(1'b0, "R10 tick before load", 1, 0);
    end
    chk(!loaded_o && !range_err_o, "R1 idle after reset", {loaded_o, range_err_o}, 0);

    for (int v = 0; v < NV; v++) begin
      per = int'(VEC[v][12:1]);
      er  = VEC[v][0];
      do_reset();
      do_write(VEC[v][20:13]);
      chk(loaded_o == 1'b1, "R2 loaded after write", loaded_o, 1);
      chk(range_err_o == er, "R9 range flag", range_err_o, er);
      wait_tick(n);
      chk(n == per, "R8/R4/R5 first tick latency", n, per);
      if (per > 1) begin
        @(negedge clk);
        chk(!tick_o, "R7 pulse width", tick_o, 0);
        wait_tick(n2);
        chk(n2 + 1 == per, "R4/R5 steady period", n2 + 1, per);
      end else begin
        @(negedge clk);
        chk(tick_o, "R6 undivided pass-through", tick_o, 1);
      end
    end

    // R2: rewrite after loading is dropped
    do_reset();
    do_write(8'h4C);
    wait_tick(n);
    do_write(8'h00);
    chk(range_err_o == 1'b0, "R2 flag held after rewrite", range_err_o, 0);
    chk(loaded_o == 1'b1, "R2 loaded held", loaded_o, 1);
    wait_tick(n2);
    chk(n2 + 1 == 104, "R2 spacing held after rewrite", n2 + 1, 104);
    wait_tick(n2);
    chk(n2 == 104, "R2 spacing held second period", n2, 104);

    // R3: bit 7 ignored, compare with same setting without it
    do_reset();
    do_write(8'h8D);
    chk(range_err_o == 1'b1, "R3 bit7 ignored flag", range_err_o, 1);
    wait_tick(n);
    chk(n == 14, "R3 bit7 ignored period", n, 14);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule